// File: doc/BRIEF.md
# Latched-Address Byte-Writable SRAM

This block is a word-organized static memory of 18-bit words whose address, chip select and write data each pass through a level-sensitive input latch before they reach the storage array. Each latch follows its input while its control is high. When the control goes low, the latch keeps the value it last took. A system can therefore present an address and data, drop the latch controls, and then move the bus on to other work while the access completes. When both latch controls are held high, the block acts as an ordinary asynchronous memory.

The word has two 9-bit lanes. Each lane has its own active-low write strobe, so a single write can update one lane or both. Reads are combinational from the latched address. The data bus is modelled as three signals: an input word, an output word, and an output-drive qualifier that stands in for the three-state condition of the pins. The qualifier is asserted only when the chip is selected, no strobe is active and output enable is low. The array size is set by `DEPTH`, and the address width is derived from it. The production build uses 65,536 words. The default is small so that simulation stays light.

Timing is modelled on a single clock. Latch hold registers take their input at a rising edge while their control is high. Array writes also take effect at a rising edge.

Top module: `sram_latched`

## Requirements
- R1: While reset is high, and after reset until a chip select is latched, `dout_en` is 0 and `dout` is all zeros. The held chip select resets to deselected (1), and the held address and data reset to 0.
- R2: While `addr_le` is 1, the address and chip select seen by the array follow the `addr` and `ce_n` inputs in the same cycle.
- R3: While `addr_le` is 0, the address and chip select in use are the values the inputs had at the last rising edge at which `addr_le` was 1.
- R4: While `data_le` is 1, the write data follows `din`. While `data_le` is 0, the write data is the value `din` had at the last rising edge at which `data_le` was 1.
- R5: With `addr_le` and `data_le` both tied to 1, a write takes effect at the next rising edge, and a read returns the stored word in the same cycle.
- R6: `wr_lo_n` = 0 with the chip selected writes bits 8:0 at the latched address and leaves bits 17:9 unchanged.
- R7: `wr_hi_n` = 0 with the chip selected writes bits 17:9 and leaves bits 8:0 unchanged. Both strobes low together write the whole word.
- R8: When the latched chip select is 1, no strobe changes the array and `dout_en` is 0.
- R9: `dout_en` is 1 exactly when the latched chip select is 0, both strobes are 1 and `oe_n` is 0. In that case `dout` is the stored word at the latched address. Otherwise `dout` is all zeros.
- R10: While either strobe is 0, `dout_en` is 0 whatever the value of `oe_n`.
- R11: In the cycle after a write, a read at the same address returns the newly written lanes together with the lanes that were left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for latch hold registers and array writes |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address |
| addr_le | input | 1 | Address/chip-select latch control (1 = transparent) |
| data_le | input | 1 | Write-data latch control (1 = transparent) |
| ce_n | input | 1 | Chip select, active low |
| wr_lo_n | input | 1 | Lower lane write strobe (bits 8:0), active low |
| wr_hi_n | input | 1 | Upper lane write strobe (bits 17:9), active low |
| oe_n | input | 1 | Output enable, active low |
| din | input | 18 | Write data |
| dout | output | 18 | Read data, zero when not driven |
| dout_en | output | 1 | Output drive qualifier (high = bus driven) |

## Verification
Two functions can fall in the same cycle. A strobe and a low output enable can be asserted together, and a write can fire while the latches are holding values the bus has already replaced. The bench produces both cases on purpose: it pulls the strobes low with `oe_n` low, and it drops `addr_le` or `data_le` and then changes `addr` and `din` before the write edge. The output qualifier must stay low during the strobe. A later read at the held address, compared against a bench model of the latches and the array, must show that the held values were the ones written and that the other lane was not touched.

// File: rtl/sram_pkg.sv
package sram_pkg;

    localparam int LANE_W    = 9;
    localparam int NUM_LANES = 2;
    localparam int WORD_W    = LANE_W * NUM_LANES;

    typedef struct packed {
        logic hi;
        logic lo;
    } lane_sel_t;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_t;

    function automatic lane_sel_t strobe_decode(input logic lo_n, input logic hi_n);
        lane_sel_t s;
        s.lo = ~lo_n;
        s.hi = ~hi_n;
        return s;
    endfunction

    function automatic acc_kind_t access_kind(input logic sel_n, input lane_sel_t s);
        if (sel_n)
            return ACC_IDLE;
        else if (s.lo || s.hi)
            return ACC_WRITE;
        else
            return ACC_READ;
    endfunction

endpackage

// File: rtl/sram_in_latch.sv
module sram_in_latch #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         le,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst)
            held <= RST_VAL;
        else if (le)
            held <= d;
    end

    // transparent while open, held value once closed
    assign q = le ? d : held;

endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [LW-1:0] wdata,
    output logic [LW-1:0] rdata
);

    logic [LW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/sram_latched.sv
module sram_latched
    import sram_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr,
    input  logic              addr_le,
    input  logic              data_le,
    input  logic              ce_n,
    input  logic              wr_lo_n,
    input  logic              wr_hi_n,
    input  logic              oe_n,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);

    logic [AW-1:0]     addr_lat;
    logic              ce_lat_n;
    logic [WORD_W-1:0] din_lat;
    logic [WORD_W-1:0] rd_word;
    logic [NUM_LANES-1:0] lane_we;
    lane_sel_t         sel;
    acc_kind_t         kind;

    // address and chip select share one latch control
    sram_in_latch #(.W(AW), .RST_VAL('0)) u_addr_lat (
        .clk(clk), .rst(rst), .le(addr_le), .d(addr), .q(addr_lat)
    );

    sram_in_latch #(.W(1), .RST_VAL(1'b1)) u_ce_lat (
        .clk(clk), .rst(rst), .le(addr_le), .d(ce_n), .q(ce_lat_n)
    );

    sram_in_latch #(.W(WORD_W), .RST_VAL('0)) u_data_lat (
        .clk(clk), .rst(rst), .le(data_le), .d(din), .q(din_lat)
    );

    assign sel  = strobe_decode(wr_lo_n, wr_hi_n);
    assign kind = access_kind(ce_lat_n, sel);

    always_comb begin
        lane_we = '0;
        if (!rst && kind == ACC_WRITE) begin
            lane_we[0] = sel.lo;
            lane_we[1] = sel.hi;
        end
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        sram_lane_bank #(.DEPTH(DEPTH), .AW(AW), .LW(LANE_W)) u_bank (
            .clk  (clk),
            .we   (lane_we[g]),
            .addr (addr_lat),
            .wdata(din_lat[g*LANE_W +: LANE_W]),
            .rdata(rd_word[g*LANE_W +: LANE_W])
        );
    end

    // the bus is driven only on a selected read with output enable low
    assign dout_en = !rst && (kind == ACC_READ) && !oe_n;
    assign dout    = dout_en ? rd_word : '0;

endmodule

// File: rtl/sram_latched_chk.sv
module sram_latched_chk #(
    parameter int AW = 11,
    parameter int WW = 18
) (
    input logic          clk,
    input logic          rst,
    input logic          addr_le,
    input logic          data_le,
    input logic          oe_n,
    input logic          wr_lo_n,
    input logic          wr_hi_n,
    input logic          ce_q,
    input logic [AW-1:0] addr_q,
    input logic [WW-1:0] din_q,
    input logic          dout_en,
    input logic [WW-1:0] dout
);

    p_reset_quiet_r1: assert property (@(posedge clk) rst |-> !dout_en);

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!addr_le && !$past(addr_le) && !$past(rst)) |-> ($stable(addr_q) && $stable(ce_q)));

    p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!data_le && !$past(data_le) && !$past(rst)) |-> $stable(din_q));

    p_deselect_r8: assert property (@(posedge clk) disable iff (rst)
        ce_q |-> !dout_en);

    p_drive_cond_r9: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> (!oe_n && !ce_q));

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !dout_en |-> (dout == '0));

    p_strobe_off_r10: assert property (@(posedge clk) disable iff (rst)
        (!wr_lo_n || !wr_hi_n) |-> !dout_en);

endmodule

bind sram_latched sram_latched_chk #(.AW(AW), .WW(18)) u_chk (
    .clk(clk), .rst(rst), .addr_le(addr_le), .data_le(data_le),
    .oe_n(oe_n), .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n),
    .ce_q(ce_lat_n), .addr_q(addr_lat), .din_q(din_lat),
    .dout_en(dout_en), .dout(dout)
);

// File: tb/sram_latched_test.sv
module sram_latched_test;

    localparam int DEPTH = 2048;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          addr_le = 1'b1;
    logic          data_le = 1'b1;
    logic          ce_n = 1'b1;
    logic          wr_lo_n = 1'b1;
    logic          wr_hi_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [17:0]   din = '0;
    logic [17:0]   dout;
    logic          dout_en;

    int checks = 0;
    int fails  = 0;

    // bench model of latches and array
    logic [AW-1:0] m_a  = '0;
    logic          m_ce = 1'b1;
    logic [17:0]   m_d  = '0;
    logic [8:0]    ml [DEPTH];
    logic [8:0]    mh [DEPTH];

    always #2 clk = ~clk;

    sram_latched #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .addr(addr), .addr_le(addr_le), .data_le(data_le),
        .ce_n(ce_n), .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n), .oe_n(oe_n),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic exp_enable(input logic sel_n, input logic lo_n,
                                        input logic hi_n, input logic o_n);
        return !sel_n && lo_n && hi_n && !o_n;
    endfunction

    task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual en/data=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [AW-1:0] a, input logic ale, input logic dle,
                        input logic c_n, input logic wl_n, input logic wh_n,
                        input logic o_n, input logic [17:0] d, input string tag);
        logic [AW-1:0] ea;
        logic          ec;
        logic [17:0]   ed;
        logic          een;
        logic [17:0]   edo;
        @(negedge clk);
        addr = a; addr_le = ale; data_le = dle; ce_n = c_n;
        wr_lo_n = wl_n; wr_hi_n = wh_n; oe_n = o_n; din = d;
        #1;
        ea  = ale ? a : m_a;
        ec  = ale ? c_n : m_ce;
        ed  = dle ? d : m_d;
        een = exp_enable(ec, wl_n, wh_n, o_n);
        edo = een ? {mh[ea], ml[ea]} : 18'd0;
        check(tag, {dout_en, dout}, {een, edo});
        @(posedge clk);
        if (ale) begin m_a = a; m_ce = c_n; end
        if (dle) m_d = d;
        if (!ec) begin
            if (!wl_n) ml[ea] = ed[8:0];
            if (!wh_n) mh[ea] = ed[17:9];
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        step(a, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 18'h0, tag);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // R1: quiet during reset even with a read requested
        repeat (3) @(posedge clk);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; addr_le = 1'b0;
        #1;
        check("R1 in reset", {dout_en, dout}, 19'd0);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: latch closed after reset keeps deselected state
        step('0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 18'h0, "R1 after reset");

        // prefill pool with full-word writes (R5)
        for (int i = 0; i < 16; i++)
            step(AW'(i), 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 18'(i * 18'h2345 + 18'h111), "R5 fill");
        step(AW'(DEPTH - 1), 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 18'h3ffff, "R10 fill top");
        rd(AW'(DEPTH - 1), "R5 read top");

        // R2: transparent address, consecutive reads
        rd(AW'(3), "R2");
        rd(AW'(7), "R2");

        // R6: lower lane only, then read back (R11)
        step(AW'(5), 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 18'h2aaaa, "R6 write");
        rd(AW'(5), "R6 R11 read");
        // R7: upper lane only
        step(AW'(6), 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 18'h15555, "R7 write");
        rd(AW'(6), "R7 R11 read");

        // R8: deselected write leaves word unchanged
        step(AW'(9), 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 18'h0beef, "R8 write");
        rd(AW'(9), "R8 read");

        // R3: latch address 10, change bus address, write lands at 10
        step(AW'(10), 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 18'h0, "R3 open");
        step(AW'(12), 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 18'h12345, "R3 held write");
        rd(AW'(10), "R3 read held");
        rd(AW'(12), "R3 other untouched");

        // R4: latch data, change bus data before write
        step(AW'(11), 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 18'h0cafe, "R4 open");
        step(AW'(11), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 18'h3f00f, "R4 held write");
        rd(AW'(11), "R4 read");

        // R9: output enable high hides a read
        step(AW'(2), 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 18'h0, "R9 oe off");

        // random mix (R9 R10 R11)
        for (int n = 0; n < 800; n++) begin
            logic [AW-1:0] ra;
            ra = ($urandom % 17 == 16) ? AW'(DEPTH - 1) : AW'($urandom % 16);
            step(ra, ($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 5) == 0,
                 ($urandom % 3) != 0, ($urandom % 3) != 0, $urandom % 2,
                 18'($urandom), "R9 random");
        end
        // reopen latches so held state is known, then sweep reads
        step('0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 18'h0, "R9 sweep");
        for (int i = 0; i < 16; i++)
            rd(AW'(i), "R11 sweep");

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        process p;
        p = process::self();
        p.srandom(32'd1975);
    end

endmodule